// File: doc/BRIEF.md
# Programmable CRC-32 Engine

This block is a register-mapped checksum engine that sits on a simple single-cycle register bus with per-byte write enables. Software chooses any 32-bit generator polynomial and any 32-bit seed. A one-shot command bit copies the seed into the running accumulator. Message data is then pushed into the data register either one byte at a time or one full word at a time. Each word write is absorbed in a single clock by a fully unrolled 32-step shift network.

Input data can be bit-reversed inside each byte or across the whole word before it is absorbed. The value read from the data register can also be returned bit-reversed. These options let reflected standards such as CRC-32 and CRC-32C be produced from a shifter that works MSB-first. Because the running value can be read back and later written as the seed, one engine can be shared between several interleaved message streams.

Top module: `crc_acc_top`

## Requirements
- R1: After reset, the data register reads 0xFFFFFFFF, the control register reads 0x00000000, the seed register reads 0xFFFFFFFF and the polynomial register reads 0x04C11DB7.
- R2: The register offsets are: data 0x00, control 0x08, seed 0x10, polynomial 0x14. Reads of any other offset return 0. Writes to any other offset change no register.
- R3: A control write with byte enable 0 set and wdata bit 0 set copies the seed into the accumulator. Control bit 0 always reads back as 0. The mode bits carried by the same write govern the data writes that follow.
- R4: Control bits 6:5 set the input reversal. 00 means none. 01 reverses the bits inside each byte lane. 11 reverses all 32 bits of the word. 10 behaves as none.
- R5: A data write with byte enables 1111 absorbs the transformed word, bit 31 first through bit 0, in one clock. The new value is readable in the next cycle.
- R6: A data write with byte enables 0001 absorbs only wdata[7:0], bit 7 first. That byte is bit-reversed when the mode is 01 or 11. A data write with any other byte-enable pattern leaves the accumulator unchanged.
- R7: When control bit 7 is set, a read of the data register returns the accumulator with its 32 bits reversed.
- R8: With polynomial 0x04C11DB7, seed 0xFFFFFFFF, input reversal and output reversal, the inverted readout after the ASCII bytes "123456789" is 0xCBF43926. With polynomial 0x1EDC6F41 and the same settings it is 0xE3069283. Both results hold whether the bytes are fed singly or as little-endian words in word-reversal mode.
- R9: A running value read from the data register (no output reversal), written later as the seed and loaded, continues the computation exactly as if it had never been interrupted.
- R10: Writes to the seed and polynomial registers update only the byte lanes whose enable is set. A control write with byte enable 0 clear changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the register |
| be_i | input | 4 | Byte-lane write enables |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, 0 when no read is requested |

## Verification
Assertions check on every cycle that:
- a load places the previous seed in the accumulator;
- a word write stores the unrolled network's result;
- any cycle with no load or accepted data write leaves the accumulator untouched;
- the polynomial changes only under a write to its own offset;
- control bit 0 never reads as 1;
- a reversed readout mirrors the accumulator's end bits.

Only the bench's scenarios can show the rest. Those are the reset values, the correct bit ordering of each reversal mode, the agreement with the two standard check values, the lane-selective register updates, and the seamless resumption of a saved context.

// File: rtl/crc_acc_pkg.sv
package crc_acc_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;

  localparam int unsigned OFS_DATA = 'h00;
  localparam int unsigned OFS_CTRL = 'h08;
  localparam int unsigned OFS_SEED = 'h10;
  localparam int unsigned OFS_POLY = 'h14;

  typedef enum logic [1:0] {
    REV_NONE = 2'b00,
    REV_BYTE = 2'b01,
    REV_RSVD = 2'b10,
    REV_WORD = 2'b11
  } rev_mode_e;

  function automatic logic [WORD_W-1:0] bit_rev(logic [WORD_W-1:0] v);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < WORD_W; i++) r[i] = v[WORD_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/crc_in_xform.sv
module crc_in_xform
  import crc_acc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] data_i,
  input  rev_mode_e    mode_i,
  output logic [W-1:0] word_o,
  output logic [7:0]   byte_o
);
  localparam int unsigned NB = W / 8;

  logic [W-1:0] lane_rev;
  logic [W-1:0] full_rev;

  for (genvar g = 0; g < W; g++) begin : g_full
    assign full_rev[g] = data_i[W-1-g];
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    for (genvar k = 0; k < 8; k++) begin : g_bit
      assign lane_rev[b*8+k] = data_i[b*8+7-k];
    end
  end

  always_comb begin
    case (mode_i)
      REV_BYTE: word_o = lane_rev;
      REV_WORD: word_o = full_rev;
      default:  word_o = data_i;
    endcase
    // single-byte ops: either reversal mode mirrors the byte
    byte_o = (mode_i == REV_BYTE || mode_i == REV_WORD) ? lane_rev[7:0] : data_i[7:0];
  end
endmodule

// File: rtl/crc_unroll.sv
module crc_unroll #(
  parameter int unsigned W = 32,
  parameter int unsigned N = 32
) (
  input  logic [W-1:0] crc_i,
  input  logic [W-1:0] poly_i,
  input  logic [N-1:0] data_i,
  output logic [W-1:0] crc_o
);
  always_comb begin
    logic [W-1:0] c;
    logic         fb;
    c = crc_i;
    for (int s = N - 1; s >= 0; s--) begin
      fb = c[W-1] ^ data_i[s];
      c  = {c[W-2:0], 1'b0} ^ ({W{fb}} & poly_i);
    end
    crc_o = c;
  end
endmodule

// File: rtl/crc_acc_top.sv
module crc_acc_top
  import crc_acc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [31:0] SEED_RST = 32'hFFFF_FFFF,
  parameter logic [31:0] POLY_RST = 32'h04C1_1DB7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam logic [LANES-1:0] BE_WORD = {LANES{1'b1}};
  localparam logic [LANES-1:0] BE_BYTE = LANES'(1);

  logic wr, rd;
  logic sel_data, sel_ctrl, sel_seed, sel_poly;
  logic load, word_op, byte_op;
  logic [WORD_W-1:0] lane_mask;

  rev_mode_e         mode_q;
  logic              out_rev_q;
  logic [WORD_W-1:0] seed_q, poly_q, acc_q, acc_d;
  logic [WORD_W-1:0] x_word, nxt_word, nxt_byte;
  logic [7:0]        x_byte;

  assign wr       = req_i & we_i;
  assign rd       = req_i & ~we_i;
  assign sel_data = (addr_i == ADDR_W'(OFS_DATA));
  assign sel_ctrl = (addr_i == ADDR_W'(OFS_CTRL));
  assign sel_seed = (addr_i == ADDR_W'(OFS_SEED));
  assign sel_poly = (addr_i == ADDR_W'(OFS_POLY));

  assign load    = wr & sel_ctrl & be_i[0] & wdata_i[0];
  assign word_op = wr & sel_data & (be_i == BE_WORD);
  assign byte_op = wr & sel_data & (be_i == BE_BYTE);

  for (genvar b = 0; b < LANES; b++) begin : g_mask
    assign lane_mask[b*8 +: 8] = {8{be_i[b]}};
  end

  crc_in_xform #(.W(WORD_W)) u_xform (
    .data_i (wdata_i),
    .mode_i (mode_q),
    .word_o (x_word),
    .byte_o (x_byte)
  );

  crc_unroll #(.W(WORD_W), .N(WORD_W)) u_step_word (
    .crc_i  (acc_q),
    .poly_i (poly_q),
    .data_i (x_word),
    .crc_o  (nxt_word)
  );

  crc_unroll #(.W(WORD_W), .N(8)) u_step_byte (
    .crc_i  (acc_q),
    .poly_i (poly_q),
    .data_i (x_byte),
    .crc_o  (nxt_byte)
  );

  always_comb begin
    if (load)         acc_d = seed_q;
    else if (word_op) acc_d = nxt_word;
    else if (byte_op) acc_d = nxt_byte;
    else              acc_d = acc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= REV_NONE;
      out_rev_q <= 1'b0;
      seed_q    <= SEED_RST;
      poly_q    <= POLY_RST;
      acc_q     <= SEED_RST;
    end else begin
      acc_q <= acc_d;
      if (wr && sel_ctrl && be_i[0]) begin
        mode_q    <= rev_mode_e'(wdata_i[6:5]);
        out_rev_q <= wdata_i[7];
      end
      if (wr && sel_seed) seed_q <= (seed_q & ~lane_mask) | (wdata_i & lane_mask);
      if (wr && sel_poly) poly_q <= (poly_q & ~lane_mask) | (wdata_i & lane_mask);
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      if (sel_data)      rdata_o = out_rev_q ? bit_rev(acc_q) : acc_q;
      else if (sel_ctrl) rdata_o[7:5] = {out_rev_q, mode_q};
      else if (sel_seed) rdata_o = seed_q;
      else if (sel_poly) rdata_o = poly_q;
    end
  end

  a_r3_load_takes_seed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> acc_q == $past(seed_q));

  a_r5_word_single_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_op |=> acc_q == $past(nxt_word));

  a_r6_idle_holds_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load || word_op || byte_op) |=> $stable(acc_q));

  a_r10_poly_only_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && sel_poly) |=> $stable(poly_q));

  a_r3_cmd_bit_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && sel_ctrl) |-> rdata_o[0] == 1'b0);

  a_r7_out_rev_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && sel_data && out_rev_q) |-> (rdata_o[31] == acc_q[0] && rdata_o[0] == acc_q[31]));
endmodule

// File: tb/crc_acc_top_bench.sv
module crc_acc_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  crc_acc_top u_crc_acc_top (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .be_i(be), .wdata_i(wdata), .rdata_o(rdata)
  );

  localparam logic [7:0] A_DATA = 8'h00, A_CTRL = 8'h08, A_SEED = 8'h10, A_POLY = 8'h14;
  localparam logic [31:0] P32 = 32'h04C11DB7, P32C = 32'h1EDC6F41;

  function automatic logic [31:0] rev32(logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  function automatic logic [31:0] revlanes(logic [31:0] v);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      for (int k = 0; k < 8; k++) r[b*8+k] = v[b*8+7-k];
    return r;
  endfunction

  function automatic logic [31:0] ref_crc(logic [31:0] c, logic [31:0] p, logic [31:0] d, int nb);
    logic fb;
    for (int i = nb - 1; i >= 0; i--) begin
      fb = c[31] ^ d[i];
      c  = {c[30:0], 1'b0} ^ (fb ? p : 32'h0);
    end
    return c;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d, logic [3:0] e);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d; be = e;
    @(posedge clk);
    #1 req = 0; we = 0; be = '0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(posedge clk);
    #1 req = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    bus_rd(A_DATA, v); check("R1 data after reset", v, 32'hFFFFFFFF);
    bus_rd(A_CTRL, v); check("R1 ctrl after reset", v, 32'h0);
    bus_rd(A_SEED, v); check("R1 seed after reset", v, 32'hFFFFFFFF);
    bus_rd(A_POLY, v); check("R1 poly after reset", v, P32);
    bus_rd(8'h04, v);  check("R2 unmapped read", v, 32'h0);
    bus_wr(8'h0C, 32'h12345678, 4'hF);
    bus_wr(8'h18, 32'h12345678, 4'hF);
    bus_rd(A_SEED, v); check("R2 stray write seed", v, 32'hFFFFFFFF);
    bus_rd(A_POLY, v); check("R2 stray write poly", v, P32);
    bus_rd(A_DATA, v); check("R2 stray write data", v, 32'hFFFFFFFF);
  endtask

  task automatic t_word_plain;
    logic [31:0] v, e;
    bus_wr(A_SEED, 32'hA5A50F0F, 4'hF);
    bus_wr(A_CTRL, 32'h1, 4'h1);
    bus_rd(A_DATA, v); check("R3 load seed", v, 32'hA5A50F0F);
    bus_wr(A_DATA, 32'h12345678, 4'hF);
    e = ref_crc(32'hA5A50F0F, P32, 32'h12345678, 32);
    bus_rd(A_DATA, v); check("R5 word no reversal", v, e);
    bus_wr(A_DATA, 32'hDEADBEEF, 4'hF);
    e = ref_crc(e, P32, 32'hDEADBEEF, 32);
    bus_rd(A_DATA, v); check("R5 second word", v, e);
  endtask

  task automatic t_byte_plain;
    logic [31:0] v, e;
    bus_wr(A_SEED, 32'h0, 4'hF);
    bus_wr(A_CTRL, 32'h1, 4'h1);
    bus_wr(A_DATA, 32'hFFFFFF31, 4'h1);
    bus_wr(A_DATA, 32'h5A5A5AC4, 4'h1);
    e = ref_crc(ref_crc(32'h0, P32, 32'h31, 8), P32, 32'hC4, 8);
    bus_rd(A_DATA, v); check("R6 byte writes use bits 7:0", v, e);
    bus_wr(A_DATA, 32'h01020304, 4'h3);
    bus_wr(A_DATA, 32'h01020304, 4'h2);
    bus_rd(A_DATA, v); check("R6 partial enables ignored", v, e);
  endtask

  task automatic t_rev_modes;
    logic [31:0] v, e;
    bus_wr(A_SEED, 32'h13579BDF, 4'hF);
    bus_wr(A_CTRL, 32'h21, 4'h1);
    bus_rd(A_CTRL, v); check("R3 mode readback, bit0 clear", v, 32'h20);
    bus_wr(A_DATA, 32'h01020304, 4'hF);
    e = ref_crc(32'h13579BDF, P32, revlanes(32'h01020304), 32);
    bus_rd(A_DATA, v); check("R4 per-byte reversal", v, e);
    bus_wr(A_CTRL, 32'h61, 4'h1);
    bus_wr(A_DATA, 32'h01020304, 4'hF);
    e = ref_crc(32'h13579BDF, P32, rev32(32'h01020304), 32);
    bus_rd(A_DATA, v); check("R4 whole-word reversal", v, e);
    bus_wr(A_DATA, 32'h0000006B, 4'h1);
    e = ref_crc(e, P32, 32'hD6, 8);
    bus_rd(A_DATA, v); check("R6 byte in word mode reversed", v, e);
    bus_wr(A_CTRL, 32'h41, 4'h1);
    bus_wr(A_DATA, 32'h01020304, 4'hF);
    e = ref_crc(32'h13579BDF, P32, 32'h01020304, 32);
    bus_rd(A_DATA, v); check("R4 mode 10 acts as none", v, e);
  endtask

  task automatic t_out_rev;
    logic [31:0] v, e;
    bus_wr(A_SEED, 32'h80000001 | 32'h00F0_0000, 4'hF);
    bus_wr(A_CTRL, 32'h81, 4'h1);
    bus_rd(A_DATA, v); check("R7 reversed readout of seed", v, rev32(32'h80F00001));
    bus_wr(A_DATA, 32'h000000A7, 4'h1);
    e = ref_crc(32'h80F00001, P32, 32'hA7, 8);
    bus_rd(A_DATA, v); check("R7 reversed readout after byte", v, rev32(e));
  endtask

  task automatic t_std(logic [31:0] p, logic [31:0] exp, string tag);
    logic [31:0] v;
    bus_wr(A_POLY, p, 4'hF);
    bus_wr(A_SEED, 32'hFFFFFFFF, 4'hF);
    bus_wr(A_CTRL, 32'hA1, 4'h1);
    for (int i = 0; i < 9; i++) bus_wr(A_DATA, 32'(8'h31 + i), 4'h1);
    bus_rd(A_DATA, v); check({"R8 bytes ", tag}, ~v, exp);
    bus_wr(A_CTRL, 32'hE1, 4'h1);
    bus_wr(A_DATA, 32'h34333231, 4'hF);
    bus_wr(A_DATA, 32'h38373635, 4'hF);
    bus_wr(A_DATA, 32'h00000039, 4'h1);
    bus_rd(A_DATA, v); check({"R8 words ", tag}, ~v, exp);
  endtask

  task automatic t_context;
    logic [31:0] v, p, e;
    bus_wr(A_POLY, P32, 4'hF);
    bus_wr(A_SEED, 32'hFFFFFFFF, 4'hF);
    bus_wr(A_CTRL, 32'h01, 4'h1);
    bus_wr(A_DATA, 32'hCAFEF00D, 4'hF);
    bus_rd(A_DATA, p);
    bus_wr(A_SEED, 32'h0, 4'hF);
    bus_wr(A_CTRL, 32'h01, 4'h1);
    bus_wr(A_DATA, 32'h0BADC0DE, 4'hF);
    bus_wr(A_SEED, p, 4'hF);
    bus_wr(A_CTRL, 32'h01, 4'h1);
    bus_wr(A_DATA, 32'h76543210, 4'hF);
    e = ref_crc(ref_crc(32'hFFFFFFFF, P32, 32'hCAFEF00D, 32), P32, 32'h76543210, 32);
    bus_rd(A_DATA, v); check("R9 context restore", v, e);
  endtask

  task automatic t_lanes;
    logic [31:0] v, a;
    bus_wr(A_SEED, 32'h11223344, 4'hF);
    bus_wr(A_SEED, 32'hAABBCCDD, 4'h4);
    bus_rd(A_SEED, v); check("R10 seed lane 2 only", v, 32'h11BB3344);
    bus_wr(A_POLY, 32'h99999999, 4'h9);
    bus_rd(A_POLY, v); check("R10 poly lanes 0 and 3", v, 32'h99C11D99);
    bus_wr(A_POLY, P32, 4'hF);
    bus_rd(A_DATA, a);
    bus_wr(A_CTRL, 32'h00000061, 4'h2);
    bus_rd(A_DATA, v); check("R10 ctrl lane0 off: no load", v, a);
    bus_rd(A_CTRL, v); check("R10 ctrl lane0 off: mode kept", v, 32'h0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_word_plain();
    t_byte_plain();
    t_rev_modes();
    t_out_rev();
    t_std(P32, 32'hCBF43926, "crc32");
    t_std(P32C, 32'hE3069283, "crc32c");
    t_context();
    t_lanes();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule